// File: doc/BRIEF.md
# Polygon List Completion Tracker

This block sits on the command stream of a tile-based rendering front end. Commands arrive as fixed 32-byte records. Each record is sent as eight consecutive 32-bit words over a valid/ready word interface. The block is always ready. It counts words to find the start of each record and reads only the type byte of that first word.

A type in the polygon-list range opens a list, and the block remembers it. A type of zero closes the list. On a close, the block raises a one-cycle completion pulse for the list kind it remembered, then forgets it. The event therefore depends on earlier records, not on the closing record. The five pulses go to an interrupt or event controller, one pulse per list kind.

Top module: `list_done_tracker`

## Requirements
- R1: `word_ready` is high in every cycle, including during reset.
- R2: Only bits 31:24 of the first word of each record (word position 0) are decoded. The upper bytes of words 1 to 7 have no effect on the stored list type or on the outputs.
- R3: A word is accepted in a cycle where `word_valid` is high. The record word position advances by one per accepted word and returns to 0 after the eighth word. Cycles with `word_valid` low do not advance it.
- R4: A first-word type in 0x80..0x84 inclusive replaces the stored list type, even if another list is already open.
- R5: A first-word type that is nonzero and outside 0x80..0x84 leaves the stored list type unchanged.
- R6: A first word with type 0x00 (end of list) produces a pulse in the cycle after it is accepted, chosen by the stored type. The mapping is: 0x80 → `done_opaque`, 0x81 → `done_opaque_mod`, 0x82 → `done_transl`, 0x83 → `done_transl_mod`, 0x84 → `done_punch`.
- R7: Every end-of-list record clears the stored list type to 0. A second end-of-list record directly after the first raises no pulse.
- R8: An end-of-list record with no stored list type raises no pulse.
- R9: Each done output is high for exactly one cycle, and at most one done output is high at a time.
- R10: Synchronous active-low reset clears the stored list type, the word position and all done outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_valid | input | 1 | Command word present |
| word_data | input | 32 | Command word |
| word_ready | output | 1 | Always high |
| done_opaque | output | 1 | Opaque list finished |
| done_opaque_mod | output | 1 | Opaque modifier list finished |
| done_transl | output | 1 | Translucent list finished |
| done_transl_mod | output | 1 | Translucent modifier list finished |
| done_punch | output | 1 | Punch-through list finished |

## Verification
The main sweep opens a record with each of the 256 type codes and closes it with an end-of-list record. This separates the five list codes, which must each raise their own pulse, from every other code, which must raise nothing. Further sequences check the remaining rules:
- A foreign code placed between open and close, and a second open code replacing the first, show that only list codes change the remembered type.
- Gaps in `word_valid` inside a record, and list-like upper bytes in words 1 to 7, show that only word position 0 is decoded.
- A double close and a reset in the middle of a list show that the remembered type is cleared.

// File: rtl/list_done_pkg.sv
// Shared constants and types for the polygon list completion tracker.
package list_done_pkg;
    localparam int WORD_W    = 32;
    localparam int TYPE_W    = 8;
    localparam int REC_WORDS = 8;
    localparam int NUM_LISTS = 5;
    localparam logic [TYPE_W-1:0] END_CODE  = 8'h00;
    localparam logic [TYPE_W-1:0] LIST_BASE = 8'h80;
    localparam logic [TYPE_W-1:0] LIST_LAST = LIST_BASE + TYPE_W'(NUM_LISTS - 1);

    typedef logic [TYPE_W-1:0] rec_type_t;
endpackage

// File: rtl/rec_word_counter.sv
// Tracks the word position inside a fixed-length record.
// Assumes every accepted word belongs to the current record; there is no resync input.
module rec_word_counter #(
    parameter int WORDS = 8,
    localparam int POS_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [POS_W-1:0] pos,
    output logic             at_first
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(WORDS - 1);

    // Advance on each accepted word; wrap after the last word of a record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (advance) begin
            pos <= (pos == LAST_POS) ? '0 : pos + POS_W'(1);
        end
    end

    assign at_first = (pos == '0);
endmodule

// File: rtl/list_type_reg.sv
// Holds the type of the currently open polygon list.
// Assumes header type is presented only with hdr_valid on the first word of a record.
module list_type_reg
    import list_done_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hdr_valid,
    input  rec_type_t hdr_type,
    output rec_type_t open_type,
    output logic      end_hit
);
    logic is_list;

    // Classify the header type.
    always_comb begin
        is_list = (hdr_type >= LIST_BASE) && (hdr_type <= LIST_LAST);
        end_hit = hdr_valid && (hdr_type == END_CODE);
    end

    // Store list-start codes; clear on end of list; ignore other codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_type <= END_CODE;
        end else if (end_hit) begin
            open_type <= END_CODE;
        end else if (hdr_valid && is_list) begin
            open_type <= hdr_type;
        end
    end
endmodule

// File: rtl/done_pulse_gen.sv
// Turns an end-of-list hit plus the open list type into one registered pulse per list kind.
// Assumes open_type is the value held before the end-of-list record updates it.
module done_pulse_gen
    import list_done_pkg::*;
#(
    parameter int LISTS = NUM_LISTS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             end_hit,
    input  rec_type_t        open_type,
    output logic [LISTS-1:0] done
);
    for (genvar i = 0; i < LISTS; i++) begin : g_list
        localparam rec_type_t CODE = LIST_BASE + TYPE_W'(i);

        // Pulse for one cycle when this list kind closes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                done[i] <= 1'b0;
            end else begin
                done[i] <= end_hit && (open_type == CODE);
            end
        end
    end
endmodule

// File: rtl/list_done_tracker.sv
// Top level: watches a 32-byte command record stream and signals polygon list completion.
// Assumes records are word-aligned from reset; always ready.
module list_done_tracker
    import list_done_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_ready,
    output logic              done_opaque,
    output logic              done_opaque_mod,
    output logic              done_transl,
    output logic              done_transl_mod,
    output logic              done_punch
);
    localparam int POS_W = $clog2(REC_WORDS);

    logic [POS_W-1:0]     rec_pos;
    logic                 at_first;
    logic                 end_hit;
    rec_type_t            cur_type;
    logic [NUM_LISTS-1:0] done_vec;

    assign word_ready = 1'b1;

    rec_word_counter #(.WORDS(REC_WORDS)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (word_valid),
        .pos      (rec_pos),
        .at_first (at_first)
    );

    list_type_reg u_type (
        .clk       (clk),
        .rst_n     (rst_n),
        .hdr_valid (word_valid && at_first),
        .hdr_type  (word_data[WORD_W-1 -: TYPE_W]),
        .open_type (cur_type),
        .end_hit   (end_hit)
    );

    done_pulse_gen #(.LISTS(NUM_LISTS)) u_done (
        .clk       (clk),
        .rst_n     (rst_n),
        .end_hit   (end_hit),
        .open_type (cur_type),
        .done      (done_vec)
    );

    assign done_opaque     = done_vec[0];
    assign done_opaque_mod = done_vec[1];
    assign done_transl     = done_vec[2];
    assign done_transl_mod = done_vec[3];
    assign done_punch      = done_vec[4];
endmodule

// File: rtl/list_done_tracker_chk.sv
// Checker for list_done_tracker; observes ports and the stored type and word position.
module list_done_tracker_chk
    import list_done_pkg::*;
#(
    parameter int POS_W = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 word_valid,
    input logic [WORD_W-1:0]    word_data,
    input logic [POS_W-1:0]     rec_pos,
    input rec_type_t            cur_type,
    input logic [NUM_LISTS-1:0] done_vec
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(REC_WORDS - 1);
    logic      hdr;
    rec_type_t hdr_ty;
    assign hdr    = word_valid && (rec_pos == '0);
    assign hdr_ty = word_data[WORD_W-1 -: TYPE_W];

    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && rec_pos == LAST_POS) |=> (rec_pos == '0));
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |=> $stable(rec_pos));
    assert_body_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && rec_pos != '0) |=> $stable(cur_type));
    assert_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr && hdr_ty >= LIST_BASE && hdr_ty <= LIST_LAST) |=> (cur_type == $past(hdr_ty)));
    assert_other_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr && hdr_ty != END_CODE && (hdr_ty < LIST_BASE || hdr_ty > LIST_LAST)) |=> $stable(cur_type));
    assert_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr && hdr_ty == END_CODE && cur_type >= LIST_BASE && cur_type <= LIST_LAST)
        |=> (done_vec == (NUM_LISTS'(1) << ($past(cur_type) - LIST_BASE))));
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr && hdr_ty == END_CODE) |=> (cur_type == END_CODE));
    assert_empty_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr && hdr_ty == END_CODE && cur_type == END_CODE) |=> (done_vec == '0));
    assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_vec));
    assert_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_vec != '0) |=> (done_vec == '0));
    assert_reset_R10: assert property (@(posedge clk)
        !rst_n |=> (done_vec == '0 && cur_type == END_CODE && rec_pos == '0));
endmodule

bind list_done_tracker list_done_tracker_chk #(.POS_W($clog2(list_done_pkg::REC_WORDS))) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_valid (word_valid),
    .word_data  (word_data),
    .rec_pos    (rec_pos),
    .cur_type   (cur_type),
    .done_vec   (done_vec)
);

// File: tb/list_done_tracker_test.sv
module list_done_tracker_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_valid = 1'b0;
    logic [31:0] word_data = '0;
    logic        word_ready;
    logic        done_opaque, done_opaque_mod, done_transl, done_transl_mod, done_punch;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    list_done_tracker uut (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
        .word_ready(word_ready), .done_opaque(done_opaque), .done_opaque_mod(done_opaque_mod),
        .done_transl(done_transl), .done_transl_mod(done_transl_mod), .done_punch(done_punch)
    );

    function automatic logic [4:0] dones();
        return {done_punch, done_transl_mod, done_transl, done_opaque_mod, done_opaque};
    endfunction

    function automatic logic [4:0] expect_for(input logic [7:0] t);
        if (t >= 8'h80 && t <= 8'h84) return 5'b1 << (t - 8'h80);
        return 5'b0;
    endfunction

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: done=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Send one record; body_top is the top byte of words 1..7; gap inserts idle cycles.
    // Samples the outputs one and two cycles after the first word is accepted.
    task automatic send_record(input logic [7:0] ty, input logic [7:0] body_top, input bit gap,
                               input string req, input logic [4:0] exp);
        for (int w = 0; w < 8; w++) begin
            @(negedge clk);
            if (w == 1) check(req, dones(), exp);
            if (w == 2) check({req, " R9"}, dones(), 5'b0);
            if (gap && w == 3) begin
                word_valid = 1'b0;
                @(negedge clk);
                @(negedge clk);
            end
            word_valid = 1'b1;
            word_data  = (w == 0) ? {ty, 24'h00A5A5} : {body_top, 24'(w)};
        end
        @(negedge clk);
        word_valid = 1'b0;
        word_data  = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1 and R10: outputs during and after reset
        n_checks++;
        if (word_ready !== 1'b1) begin
            n_fail++;
            $display("FAIL R1: ready=%b expected 1", word_ready);
        end
        @(negedge clk);
        rst_n = 1'b1;
        check("R10 reset", dones(), 5'b0);

        // R4 R5 R6 R8: sweep every type code as list opener, then close
        for (int t = 0; t < 256; t++) begin
            send_record(8'(t), 8'h11, 1'b0, "R5 opener", 5'b0);
            send_record(8'h00, 8'h22, 1'b0, "R6 sweep close", expect_for(8'(t)));
        end

        // R8: end with nothing open
        send_record(8'h00, 8'h00, 1'b0, "R8 idle", 5'b0);
        send_record(8'h00, 8'h00, 1'b0, "R8 empty end", 5'b0);

        // R5: foreign code between open and close keeps the list
        send_record(8'h82, 8'h00, 1'b0, "R4 open", 5'b0);
        send_record(8'h45, 8'h00, 1'b0, "R5 foreign", 5'b0);
        send_record(8'hFF, 8'h00, 1'b0, "R5 foreign", 5'b0);
        send_record(8'h00, 8'h00, 1'b0, "R5 close keeps list", 5'b00100);

        // R4: a later list code replaces the earlier one
        send_record(8'h80, 8'h00, 1'b0, "R4 open", 5'b0);
        send_record(8'h83, 8'h00, 1'b0, "R4 replace", 5'b0);
        send_record(8'h00, 8'h00, 1'b0, "R4 close replaced", 5'b01000);

        // R7: double close
        send_record(8'h84, 8'h00, 1'b0, "R7 open", 5'b0);
        send_record(8'h00, 8'h00, 1'b0, "R7 first close", 5'b10000);
        send_record(8'h00, 8'h00, 1'b0, "R7 second close", 5'b0);

        // R2 R3: list-like bytes in body words and gaps in valid
        send_record(8'h81, 8'h00, 1'b1, "R3 open with gap", 5'b0);
        send_record(8'h10, 8'h84, 1'b1, "R2 body list code", 5'b0);
        send_record(8'h00, 8'h80, 1'b1, "R2 close after body", 5'b00010);
        send_record(8'h20, 8'h00, 1'b0, "R2 body end code", 5'b0);
        send_record(8'h00, 8'h00, 1'b0, "R3 aligned close", 5'b0);

        // R10: reset mid-list and mid-record clears state
        send_record(8'h80, 8'h00, 1'b0, "R10 open", 5'b0);
        @(negedge clk);
        word_valid = 1'b1;
        word_data  = {8'h81, 24'h0};
        @(negedge clk);
        word_data  = {8'h00, 24'h1};
        @(negedge clk);
        word_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R10 after reset", dones(), 5'b0);
        send_record(8'h00, 8'h00, 1'b0, "R10 close after reset", 5'b0);

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        finished = 1'b1;
        $finish;
    end
endmodule